// File: doc/BRIEF.md
# Sample Output Formatter with Test Pattern Source

This block sits between the corrected output of a 16-bit converter core and the pins that carry samples off chip. Each raw sample arrives as offset binary with an out-of-range flag. The block re-codes it as offset binary, two's complement or Gray code. A selected digital test pattern can take its place. The formatted word is registered together with its flag.

The registered word is available as a parallel word. It is also split across eight lanes for a double-data-rate link: each lane carries one even/odd pair of adjacent bits, one bit per half of the output clock. A data-valid strobe of selectable polarity marks each held word.

Samples enter and leave over valid/ready handshakes. A sample is taken when `in_valid` and `in_ready` are both high at a rising edge. The output register holds its word and flag while `out_valid` is high and `out_ready` is low. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle, so at most one word is ever held and no sample is lost or duplicated. The configuration inputs are static register fields. The coding and pattern fields apply to the sample at the moment it is accepted. The strobe polarity, lane enable and phase act directly on the registered word.

Top module: `sample_formatter`

## Requirements
- R1: With `cfg_format` 0 (offset binary) or 3 (reserved), and `cfg_pattern` 0, the output word equals the raw sample unchanged.
- R2: With `cfg_format` 1 (two's complement), the output word is the raw sample with bit 15 inverted and all other bits unchanged.
- R3: With `cfg_format` 2 (Gray), the output word is `s ^ (s >> 1)` of the raw sample `s`.
- R4: `cfg_pattern` selects a fixed level that replaces the coded sample, regardless of `cfg_format`. The levels are: 1 gives 16'h8000 (mid-scale), 2 gives 16'h0000 (negative full scale), and 3 gives 16'hFFFF (positive full scale).
- R5: `cfg_pattern` 4 gives a toggle pattern. A toggle state flips on every accepted sample, in every mode. The word taken on an even-numbered acceptance since reset is 16'hFFFF, and on an odd-numbered one it is 16'h0000; the first acceptance counts as number 0.
- R6: `cfg_pattern` 5 gives the value on `cfg_custom`. Pattern 6 gives 16'hAAAA, and pattern 7 gives 16'h5555.
- R7: A sample accepted at a rising edge appears on `out_word`, with `out_valid` high, right after that same edge. `out_otr` carries the flag accepted with that sample.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_word`, `out_otr` and `out_valid` stay unchanged at the next edge.
- R9: `out_dav` equals `out_valid` when `cfg_dav_inv` is 0, and its complement when `cfg_dav_inv` is 1.
- R10: With `cfg_ddr_en` 1, lane i drives word bit 2i when `ddr_phase` is 0 (output clock high) and bit 2i+1 when `ddr_phase` is 1. With `cfg_ddr_en` 0, all lanes drive 0.
- R11: During and after reset, before any sample is accepted, `out_valid` is 0, `out_word` is 0 and `out_otr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Raw sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_sample | input | 16 | Raw sample, offset binary |
| in_otr | input | 1 | Out-of-range flag of the raw sample |
| cfg_format | input | 2 | Coding: 0 offset, 1 two's complement, 2 Gray, 3 offset |
| cfg_pattern | input | 3 | Test pattern select, 0 = none |
| cfg_custom | input | 16 | Word used by pattern 5 |
| cfg_dav_inv | input | 1 | Invert the data-valid strobe |
| cfg_ddr_en | input | 1 | Enable lane output for double data rate |
| ddr_phase | input | 1 | Half of output clock: 0 even bits, 1 odd bits |
| out_valid | output | 1 | Registered word present |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_word | output | 16 | Registered formatted word |
| out_otr | output | 1 | Out-of-range flag aligned with `out_word` |
| out_dav | output | 1 | Data-valid strobe, polarity per `cfg_dav_inv` |
| ddr_lane | output | 8 | Double-data-rate lane bits |

## Verification
The assertions assume two things. First, `rst_n` is held low for at least one edge. Second, the configuration fields stay stable while a toggle-pattern run is in progress: the toggle check compares consecutive accepted words and relies on pattern 4 being selected for both. The Gray check inside the coder applies only once the raw sample is a known value. The stimulus changes configuration only between groups of samples, holds `in_valid` low through reset, and drives `out_ready` from a pseudo-random sequence so that stalls of different lengths occur.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  typedef enum logic [1:0] {
    CODE_OFFSET = 2'd0,
    CODE_TWOS   = 2'd1,
    CODE_GRAY   = 2'd2,
    CODE_SPARE  = 2'd3
  } code_sel_e;

  typedef enum logic [2:0] {
    PAT_NONE   = 3'd0,
    PAT_MID    = 3'd1,
    PAT_NEG_FS = 3'd2,
    PAT_POS_FS = 3'd3,
    PAT_TOGGLE = 3'd4,
    PAT_USER   = 3'd5,
    PAT_ALT_HI = 3'd6,
    PAT_ALT_LO = 3'd7
  } pat_sel_e;
endpackage

// File: rtl/fmt_coder.sv
module fmt_coder
  import fmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] raw,
  input  code_sel_e    sel,
  output logic [W-1:0] coded
);
  localparam int TOP = W - 1;

  logic [W-1:0] as_twos;
  logic [W-1:0] as_gray;

  always_comb begin
    as_twos      = raw;
    as_twos[TOP] = ~raw[TOP];
  end

  assign as_gray = raw ^ (raw >> 1);

  always_comb begin
    unique case (sel)
      CODE_TWOS: coded = as_twos;
      CODE_GRAY: coded = as_gray;
      default:   coded = raw;
    endcase
  end

  function automatic logic [W-1:0] gray_decode(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[TOP] = g[TOP];
    for (int i = TOP - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_comb begin
    if (!$isunknown(raw)) begin
      assert_gray_roundtrip_R3: assert (gray_decode(as_gray) == raw)
        else $error("gray code does not decode back to the sample");
      assert_twos_one_bit_R2: assert ($countones(as_twos ^ raw) == 1 && (as_twos[TOP] != raw[TOP]))
        else $error("two's complement differs from offset in more than the sign bit");
    end
  end
endmodule

// File: rtl/fmt_patgen.sv
module fmt_patgen
  import fmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  pat_sel_e     sel,
  input  logic [W-1:0] custom,
  output logic         active,
  output logic [W-1:0] pattern
);
  localparam logic [W-1:0] ALL_ONE = {W{1'b1}};
  localparam logic [W-1:0] MID     = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] alt_hi;
  logic         tog_q;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_alt
      assign alt_hi[gi] = (gi % 2) == 1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)   tog_q <= 1'b0;
    else if (adv) tog_q <= ~tog_q;
  end

  assign active = (sel != PAT_NONE);

  always_comb begin
    unique case (sel)
      PAT_MID:    pattern = MID;
      PAT_NEG_FS: pattern = '0;
      PAT_POS_FS: pattern = ALL_ONE;
      PAT_TOGGLE: pattern = tog_q ? '0 : ALL_ONE;
      PAT_USER:   pattern = custom;
      PAT_ALT_HI: pattern = alt_hi;
      PAT_ALT_LO: pattern = ~alt_hi;
      default:    pattern = '0;
    endcase
  end

  assert_toggle_flips_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && adv && $past(adv) && sel == PAT_TOGGLE && $past(sel) == PAT_TOGGLE)
      |-> (pattern == ~$past(pattern)))
    else $error("toggle pattern did not flip between accepted samples");
endmodule

// File: rtl/fmt_lane_pack.sv
module fmt_lane_pack #(
  parameter int W = 16
) (
  input  logic [W-1:0]   word,
  input  logic           ddr_en,
  input  logic           phase,
  output logic [W/2-1:0] lanes
);
  localparam int LANES = W / 2;

  genvar li;
  generate
    for (li = 0; li < LANES; li++) begin : g_lane
      logic even_b;
      logic odd_b;
      assign even_b    = word[2*li];
      assign odd_b     = word[2*li+1];
      assign lanes[li] = ddr_en & (phase ? odd_b : even_b);
    end
  endgenerate

  always_comb begin
    if (!$isunknown({word, ddr_en, phase}) && ddr_en)
      assert_lane_weight_R10: assert ($countones(lanes) <= $countones(word))
        else $error("lanes carry more ones than the word");
  end
endmodule

// File: rtl/sample_formatter.sv
module sample_formatter
  import fmt_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [SAMPLE_W-1:0]   in_sample,
  input  logic                  in_otr,
  input  logic [1:0]            cfg_format,
  input  logic [2:0]            cfg_pattern,
  input  logic [SAMPLE_W-1:0]   cfg_custom,
  input  logic                  cfg_dav_inv,
  input  logic                  cfg_ddr_en,
  input  logic                  ddr_phase,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [SAMPLE_W-1:0]   out_word,
  output logic                  out_otr,
  output logic                  out_dav,
  output logic [SAMPLE_W/2-1:0] ddr_lane
);
  localparam int LANES = SAMPLE_W / 2;

  logic                in_fire;
  logic [SAMPLE_W-1:0] coded;
  logic [SAMPLE_W-1:0] pat_word;
  logic                pat_on;
  logic [SAMPLE_W-1:0] next_word;
  logic [LANES-1:0]    lanes_w;

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  fmt_coder #(.W(SAMPLE_W)) u_coder (
    .raw   (in_sample),
    .sel   (code_sel_e'(cfg_format)),
    .coded (coded)
  );

  fmt_patgen #(.W(SAMPLE_W)) u_patgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (in_fire),
    .sel     (pat_sel_e'(cfg_pattern)),
    .custom  (cfg_custom),
    .active  (pat_on),
    .pattern (pat_word)
  );

  assign next_word = pat_on ? pat_word : coded;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_otr   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= next_word;
        out_otr  <= in_otr;
      end
    end
  end

  assign out_dav = out_valid ^ cfg_dav_inv;

  fmt_lane_pack #(.W(SAMPLE_W)) u_pack (
    .word   (out_word),
    .ddr_en (cfg_ddr_en),
    .phase  (ddr_phase),
    .lanes  (lanes_w)
  );
  assign ddr_lane = lanes_w;

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_otr)))
    else $error("output changed while stalled");

  assert_valid_from_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid))
    else $error("output became valid without an accepted sample");

  assert_drain_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid)
    else $error("output stayed valid after drain with no new sample");
endmodule

// File: tb/test_sample_formatter.sv
`timescale 1ns/100ps
module test_sample_formatter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [15:0] in_sample = 0;
  logic        in_otr = 0;
  logic [1:0]  cfg_format = 0;
  logic [2:0]  cfg_pattern = 0;
  logic [15:0] cfg_custom = 16'h1234;
  logic        cfg_dav_inv = 0;
  logic        cfg_ddr_en = 0;
  logic        ddr_phase = 0;
  logic        out_valid;
  logic        out_ready = 0;
  logic [15:0] out_word;
  logic        out_otr;
  logic        out_dav;
  logic [7:0]  ddr_lane;

  int checks = 0;
  int fails = 0;
  int accepted = 0;
  bit done = 0;
  bit mon_on = 0;
  logic [16:0] expq[$];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  sample_formatter i_sample_formatter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .in_otr(in_otr), .cfg_format(cfg_format),
    .cfg_pattern(cfg_pattern), .cfg_custom(cfg_custom), .cfg_dav_inv(cfg_dav_inv),
    .cfg_ddr_en(cfg_ddr_en), .ddr_phase(ddr_phase), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .out_otr(out_otr),
    .out_dav(out_dav), .ddr_lane(ddr_lane)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [15:0] s, input int acc);
    case (cfg_pattern)
      3'd1: return 16'h8000;             // R4
      3'd2: return 16'h0000;             // R4
      3'd3: return 16'hFFFF;             // R4
      3'd4: return (acc % 2 == 0) ? 16'hFFFF : 16'h0000; // R5
      3'd5: return cfg_custom;           // R6
      3'd6: return 16'hAAAA;             // R6
      3'd7: return 16'h5555;             // R6
      default: begin
        case (cfg_format)
          2'd1: return s ^ 16'h8000;     // R2
          2'd2: return s ^ (s >> 1);     // R3
          default: return s;             // R1
        endcase
      end
    endcase
  endfunction

  // driver: pushes expected items when a sample is accepted
  task automatic send(input logic [15:0] s, input logic f);
    @(negedge clk);
    in_valid  = 1;
    in_sample = s;
    in_otr    = f;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    expq.push_back({f, model(s, accepted)});
    accepted++;
    @(posedge clk);
    #0.5;
    in_valid = 0;
  endtask

  // monitor: compares outputs at each negedge
  always @(negedge clk) begin
    if (mon_on) begin
      logic [16:0] e;
      chk(out_dav == (out_valid ^ cfg_dav_inv), "R9 dav", {31'b0, out_dav}, {31'b0, out_valid ^ cfg_dav_inv});
      if (out_valid) begin
        ddr_phase = 0;
        #0.2;
        for (int i = 0; i < 8; i++) begin
          logic eb;
          eb = cfg_ddr_en & out_word[2*i];
          if (ddr_lane[i] !== eb) chk(0, "R10 even lane", {24'b0, ddr_lane}, {31'b0, eb});
        end
        ddr_phase = 1;
        #0.2;
        for (int i = 0; i < 8; i++) begin
          logic ob;
          ob = cfg_ddr_en & out_word[2*i+1];
          if (ddr_lane[i] !== ob) chk(0, "R10 odd lane", {24'b0, ddr_lane}, {31'b0, ob});
        end
        chk(1, "R10", 0, 0);
      end
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(0, "R7 unexpected word", {15'b0, out_otr, out_word}, 0);
        else begin
          e = expq.pop_front();
          chk({out_otr, out_word} === e, "R1-6 word/otr (R7 R8)", {15'b0, out_otr, out_word}, {15'b0, e});
        end
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[3];
      #0.1;
      chk(in_ready == (!out_valid || out_ready), "R8 ready", {31'b0, in_ready}, {31'b0, !out_valid || out_ready});
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cfg_dav_inv = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 0, "R11 valid", {31'b0, out_valid}, 0);
    chk(out_word == 0 && out_otr == 0, "R11 word", {15'b0, out_otr, out_word}, 0);
    chk(out_dav == 1, "R11 R9 dav inverted idle", {31'b0, out_dav}, 1);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0 && ddr_lane == 0, "R11 after release", {23'b0, out_valid, ddr_lane}, 0);
    mon_on = 1;
    // R1 R2 R3: all codings, including corner samples
    for (int fm = 0; fm < 4; fm++) begin
      cfg_format = fm[1:0];
      cfg_ddr_en = fm[0];
      cfg_dav_inv = fm[1];
      send(16'h0000, 0); send(16'hFFFF, 1); send(16'h8000, 0); send(16'h7FFF, 1);
      for (int k = 0; k < 20; k++) send(16'($urandom), 1'($urandom));
    end
    // R4 R5 R6: every pattern, under varied coding
    cfg_custom = 16'hC3A5;
    for (int p = 1; p < 8; p++) begin
      cfg_pattern = p[2:0];
      cfg_format = 2'(p % 4);
      cfg_ddr_en = p[0];
      for (int k = 0; k < 12; k++) send(16'($urandom), 1'($urandom));
    end
    cfg_pattern = 0;
    cfg_ddr_en = 1;
    // R8: back-to-back stream under random back-pressure
    for (int k = 0; k < 200; k++) send(16'($urandom), 1'($urandom));
    repeat (60) @(posedge clk);
    chk(expq.size() == 0, "R7 drained", expq.size(), 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule